// File: doc/BRIEF.md
# Palette DAC Port Register Model

This block models the processor-facing byte ports of a palette DAC that also contains a programmable clock synthesizer. Four byte ports are decoded: a pixel mask, a read index, a write index and a data port. Through the data port the host reaches a colour lookup table whose entries are red/green/blue triplets. When the external clock-select input is high, the same index and data ports reach a bank of clock-synthesizer divider pairs instead.

A command register that controls the pixel format is hidden behind the pixel-mask port. The host makes four back-to-back reads of the mask port to arm it. The next access to that port, whether a read or a write, then reaches the command register. On the variant that carries an identity byte, the fourth of those reads returns that byte. The decoded pixel format, the pixel mask and the programmable pixel-clock divider pair drive the rest of the display path.

Port selection on `addr` is 0 for the pixel mask, 1 for the read index, 2 for the write index and 3 for data.

Top module: `dac_port_regs`

## Requirements
- R1: After reset the pixel mask is 0xFF, the command register is 0x00 (`pix_fmt` = 0), both indices are 0, every palette byte is 0, the programmable clock pair is 0 and `rd_valid` is low.
- R2: A read (`cs`=1, `we`=0) presents its byte on `rdata` with `rd_valid` high on the cycle after the access. `rd_valid` is low after any cycle that is not a read.
- R3: After four consecutive reads of port 0, the next port-0 access (read or write) reaches the command register and not the mask. The unlock count then restarts, so the following port-0 read returns the mask.
- R4: Any access other than a port-0 read clears the unlock count. This includes a read of the write-index port and a port-0 write made before the count is armed, and such a write updates the mask.
- R5: With HAS_CHIP_ID=1 (default), the fourth consecutive port-0 read returns CHIP_ID (0x73, upper nibble 0x7). With HAS_CHIP_ID=0 it returns the mask.
- R6: With clock-select low, data-port writes fill red, green and blue of the write-index entry and then advance to the next entry. The index wraps from 255 to 0.
- R7: Data-port reads step through the palette using the read index, which is independent of the write index.
- R8: Reading port 1 or port 2 returns the read or write index. Writing either port loads that index and returns its component pointer to the first byte (red, or M).
- R9: With clock-select high, each clock entry is two bytes, M then N, and the data port alternates between them. Entry 2 is writable and drives `pclk_m` and `pclk_n`.
- R10: Clock entries 0 and 1 always read as M=0x28, N=0x61 and M=0x3D, N=0x62. Writes to them are ignored, but the pointer still advances.
- R11: Clock index 0x0E holds a single byte. One data access there advances the pointer to index 0x0F.
- R12: `pix_fmt` decodes the command register as 0 = palette, 1 = 5-5-5, 2 = 5-6-5, 3 = 32-bit. On the identity variant, bits [7:5] of 001 give 1, 011 give 2 and 010 give 3, and any other value gives 0. On the plain variant, bit 7 set gives 1.
- R13: Data-port writes made with clock-select high leave the palette unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Access strobe, one access per cycle |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 2 | Port select: 0 mask, 1 read index, 2 write index, 3 data |
| wdata | input | 8 | Write byte |
| clk_sel | input | 1 | 1 = index/data ports reach clock registers |
| rdata | output | 8 | Read byte, valid the cycle after a read |
| rd_valid | output | 1 | Marks `rdata` as carrying a read result |
| pix_mask | output | 8 | Current pixel mask |
| pix_fmt | output | 2 | Decoded pixel format |
| pclk_m | output | 8 | Programmable pixel clock M divider |
| pclk_n | output | 8 | Programmable pixel clock N divider |

## Verification
The bench targets the unlock sequence at its edges. A count that is not cleared by an index-port read, or by a mask write made before arming, would leak the command register into an ordinary mask access. A count that is not restarted after the hidden access would return the identity byte or the command byte where the mask belongs. Writes to the fixed clock entries and the single-byte control index are checked through later readback. A bank that accepted those writes, or a pointer that stepped the wrong amount, shows up as wrong bytes at the following indices. Triplet wrap at index 255 and the separation of the palette from clock-mode writes are also checked by reading back.

// File: rtl/dac_port_pkg.sv
package dac_port_pkg;

  typedef enum logic [1:0] {
    PORT_MASK = 2'd0,
    PORT_RIDX = 2'd1,
    PORT_WIDX = 2'd2,
    PORT_DATA = 2'd3
  } port_e;

  typedef enum logic [1:0] {
    FMT_LUT    = 2'd0,
    FMT_RGB555 = 2'd1,
    FMT_RGB565 = 2'd2,
    FMT_RGB32  = 2'd3
  } pix_fmt_e;

  // True when the byte at comp is the last one of the addressed entry.
  function automatic logic is_last_comp(input logic clk_mode, input logic [7:0] idx,
                                        input logic [1:0] comp, input logic [7:0] single_idx);
    if (!clk_mode)          return comp == 2'd2;
    if (idx == single_idx)  return 1'b1;
    return comp == 2'd1;
  endfunction

  // Fixed read-only synthesizer entries 0 and 1.
  function automatic logic [7:0] fixed_clk_byte(input logic entry, input logic is_n);
    case ({entry, is_n})
      2'b00:   return 8'h28;
      2'b01:   return 8'h61;
      2'b10:   return 8'h3D;
      default: return 8'h62;
    endcase
  endfunction

  function automatic pix_fmt_e decode_fmt(input logic extended, input logic [7:0] cmd);
    if (!extended) return cmd[7] ? FMT_RGB555 : FMT_LUT;
    case (cmd[7:5])
      3'b001:  return FMT_RGB555;
      3'b011:  return FMT_RGB565;
      3'b010:  return FMT_RGB32;
      default: return FMT_LUT;
    endcase
  endfunction

endpackage

// File: rtl/dac_unlock.sv
module dac_unlock #(
  parameter int N_READS = 4,
  localparam int CW = $clog2(N_READS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc,
  input  logic          mask_rd,
  output logic [CW-1:0] cnt,
  output logic          armed,
  output logic          id_read
);
  localparam logic [CW-1:0] FULL = CW'(N_READS);
  localparam logic [CW-1:0] LAST = CW'(N_READS - 1);

  assign armed   = (cnt == FULL);
  assign id_read = mask_rd && (cnt == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)                cnt <= '0;
    else if (acc) begin
      if (mask_rd && !armed)   cnt <= cnt + 1'b1;
      else                     cnt <= '0;
    end
  end
endmodule

// File: rtl/dac_index_ptr.sv
module dac_index_ptr
  import dac_port_pkg::*;
#(
  parameter logic [7:0] SINGLE_IDX = 8'h0E
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [7:0] load_val,
  input  logic       step,
  input  logic       clk_mode,
  output logic [7:0] idx,
  output logic [1:0] comp,
  output logic       entry_done
);
  assign entry_done = step && is_last_comp(clk_mode, idx, comp, SINGLE_IDX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx  <= '0;
      comp <= '0;
    end else if (load) begin
      idx  <= load_val;
      comp <= '0;
    end else if (entry_done) begin
      idx  <= idx + 1'b1;
      comp <= '0;
    end else if (step) begin
      comp <= comp + 1'b1;
    end
  end
endmodule

// File: rtl/dac_palette.sv
module dac_palette #(
  parameter int ENTRIES = 256,
  localparam int EAW   = $clog2(ENTRIES),
  localparam int DEPTH = ENTRIES * 3,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           we,
  input  logic [EAW-1:0] wr_ent,
  input  logic [1:0]     wr_comp,
  input  logic [7:0]     wdata,
  input  logic [EAW-1:0] rd_ent,
  input  logic [1:0]     rd_comp,
  output logic [7:0]     rd_data
);
  logic [7:0] mem [DEPTH];

  function automatic logic [AW-1:0] slot(input logic [EAW-1:0] e, input logic [1:0] c);
    return AW'(e) * AW'(3) + AW'(c);
  endfunction

  assign rd_data = mem[slot(rd_ent, rd_comp)];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) mem[k] <= '0;
    end else if (we) begin
      mem[slot(wr_ent, wr_comp)] <= wdata;
    end
  end
endmodule

// File: rtl/dac_clkbank.sv
module dac_clkbank
  import dac_port_pkg::*;
#(
  parameter int ENTRIES       = 16,
  parameter int FIXED_ENTRIES = 2,
  parameter int PROG_IDX      = 2,
  localparam int AW = $clog2(ENTRIES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] wr_ent,
  input  logic          wr_is_n,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] rd_ent,
  input  logic          rd_is_n,
  output logic [7:0]    rd_data,
  output logic [7:0]    prog_m,
  output logic [7:0]    prog_n
);
  localparam logic [AW-1:0] FIX_LIM = AW'(FIXED_ENTRIES);
  localparam logic [AW-1:0] PROG    = AW'(PROG_IDX);

  logic [7:0] m_q [ENTRIES];
  logic [7:0] n_q [ENTRIES];
  logic       wr_fixed, rd_fixed;

  assign wr_fixed = (wr_ent < FIX_LIM);
  assign rd_fixed = (rd_ent < FIX_LIM);

  assign rd_data = rd_fixed ? fixed_clk_byte(rd_ent[0], rd_is_n)
                            : (rd_is_n ? n_q[rd_ent] : m_q[rd_ent]);
  assign prog_m  = m_q[PROG];
  assign prog_n  = n_q[PROG];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < ENTRIES; k++) begin
        m_q[k] <= '0;
        n_q[k] <= '0;
      end
    end else if (we && !wr_fixed) begin
      if (wr_is_n) n_q[wr_ent] <= wdata;
      else         m_q[wr_ent] <= wdata;
    end
  end
endmodule

// File: rtl/dac_port_regs.sv
module dac_port_regs
  import dac_port_pkg::*;
#(
  parameter int         PAL_ENTRIES  = 256,
  parameter int         CLK_ENTRIES  = 16,
  parameter int         UNLOCK_READS = 4,
  parameter bit         HAS_CHIP_ID  = 1'b1,
  parameter logic [7:0] CHIP_ID      = 8'h73,
  parameter logic [7:0] PLL_CTRL_IDX = 8'h0E,
  localparam int PAL_AW = $clog2(PAL_ENTRIES),
  localparam int CLK_AW = $clog2(CLK_ENTRIES),
  localparam int CW     = $clog2(UNLOCK_READS + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs,
  input  logic       we,
  input  logic [1:0] addr,
  input  logic [7:0] wdata,
  input  logic       clk_sel,
  output logic [7:0] rdata,
  output logic       rd_valid,
  output logic [7:0] pix_mask,
  output logic [1:0] pix_fmt,
  output logic [7:0] pclk_m,
  output logic [7:0] pclk_n
);
  // Named access events
  logic rd_acc, wr_acc, sel_mask, sel_ridx, sel_widx, sel_data;
  logic mask_rd, mask_wr, hidden_rd, hidden_wr, data_rd, data_wr;
  logic armed, id_read;
  logic [CW-1:0] unl_cnt;
  logic [7:0] mask_q, cmd_q, rdata_q, read_byte, fourth_val, pal_rd, clk_rd;
  logic       rd_valid_q;
  logic [7:0] rd_idx, wr_idx;
  logic [1:0] rd_comp, wr_comp;
  logic       rd_entry_done, wr_entry_done;
  pix_fmt_e   fmt;

  assign rd_acc   = cs && !we;
  assign wr_acc   = cs && we;
  assign sel_mask = (addr == PORT_MASK);
  assign sel_ridx = (addr == PORT_RIDX);
  assign sel_widx = (addr == PORT_WIDX);
  assign sel_data = (addr == PORT_DATA);

  assign mask_rd   = rd_acc && sel_mask;
  assign hidden_rd = mask_rd && armed;
  assign hidden_wr = wr_acc && sel_mask && armed;
  assign mask_wr   = wr_acc && sel_mask && !armed;
  assign data_rd   = rd_acc && sel_data;
  assign data_wr   = wr_acc && sel_data;

  dac_unlock #(.N_READS(UNLOCK_READS)) u_unlock (
    .clk, .rst_n, .acc(cs), .mask_rd,
    .cnt(unl_cnt), .armed, .id_read
  );

  dac_index_ptr #(.SINGLE_IDX(PLL_CTRL_IDX)) u_rd_ptr (
    .clk, .rst_n, .load(wr_acc && sel_ridx), .load_val(wdata),
    .step(data_rd), .clk_mode(clk_sel),
    .idx(rd_idx), .comp(rd_comp), .entry_done(rd_entry_done)
  );

  dac_index_ptr #(.SINGLE_IDX(PLL_CTRL_IDX)) u_wr_ptr (
    .clk, .rst_n, .load(wr_acc && sel_widx), .load_val(wdata),
    .step(data_wr), .clk_mode(clk_sel),
    .idx(wr_idx), .comp(wr_comp), .entry_done(wr_entry_done)
  );

  dac_palette #(.ENTRIES(PAL_ENTRIES)) u_pal (
    .clk, .rst_n, .we(data_wr && !clk_sel),
    .wr_ent(wr_idx[PAL_AW-1:0]), .wr_comp, .wdata,
    .rd_ent(rd_idx[PAL_AW-1:0]), .rd_comp, .rd_data(pal_rd)
  );

  dac_clkbank #(.ENTRIES(CLK_ENTRIES)) u_clk (
    .clk, .rst_n, .we(data_wr && clk_sel),
    .wr_ent(wr_idx[CLK_AW-1:0]), .wr_is_n(wr_comp[0]), .wdata,
    .rd_ent(rd_idx[CLK_AW-1:0]), .rd_is_n(rd_comp[0]), .rd_data(clk_rd),
    .prog_m(pclk_m), .prog_n(pclk_n)
  );

  // Variant choice for the last counted mask read
  generate
    if (HAS_CHIP_ID) begin : g_id
      assign fourth_val = CHIP_ID;
    end else begin : g_plain
      assign fourth_val = mask_q;
    end
  endgenerate

  always_comb begin
    unique case (addr)
      PORT_MASK: read_byte = hidden_rd ? cmd_q : (id_read ? fourth_val : mask_q);
      PORT_RIDX: read_byte = rd_idx;
      PORT_WIDX: read_byte = wr_idx;
      default:   read_byte = clk_sel ? clk_rd : pal_rd;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_q     <= 8'hFF;
      cmd_q      <= 8'h00;
      rdata_q    <= 8'h00;
      rd_valid_q <= 1'b0;
    end else begin
      if (mask_wr)   mask_q <= wdata;
      if (hidden_wr) cmd_q  <= wdata;
      rd_valid_q <= rd_acc;
      if (rd_acc) rdata_q <= read_byte;
    end
  end

  assign fmt      = decode_fmt(HAS_CHIP_ID, cmd_q);
  assign pix_fmt  = fmt;
  assign pix_mask = mask_q;
  assign rdata    = rdata_q;
  assign rd_valid = rd_valid_q;
endmodule

// File: rtl/dac_port_regs_chk.sv
module dac_port_regs_chk #(
  parameter int         UNLOCK_READS = 4,
  parameter bit         HAS_CHIP_ID  = 1'b1,
  parameter logic [7:0] PLL_CTRL_IDX = 8'h0E,
  localparam int CW = $clog2(UNLOCK_READS + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cs,
  input logic          we,
  input logic [1:0]    addr,
  input logic [7:0]    wdata,
  input logic          clk_sel,
  input logic [7:0]    rdata,
  input logic          rd_valid,
  input logic [7:0]    pix_mask,
  input logic [CW-1:0] unl_cnt,
  input logic [7:0]    cmd_q,
  input logic [7:0]    rd_idx,
  input logic [1:0]    rd_comp,
  input logic [7:0]    wr_idx,
  input logic [1:0]    wr_comp
);
  localparam logic [CW-1:0] FULL = CW'(UNLOCK_READS);
  localparam logic [CW-1:0] LAST = CW'(UNLOCK_READS - 1);

  assert_rd_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && !we) |=> rd_valid);
  assert_no_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(cs && !we) |=> !rd_valid);
  assert_count_up_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && !we && addr == 2'd0 && unl_cnt != FULL) |=> unl_cnt == CW'($past(unl_cnt) + 1'b1));
  assert_hidden_wr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && we && addr == 2'd0 && unl_cnt == FULL) |=> (cmd_q == $past(wdata) && $stable(pix_mask) && unl_cnt == '0));
  assert_widx_read_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && !we && addr == 2'd2) |=> unl_cnt == '0);
  assert_chip_id_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (HAS_CHIP_ID && cs && !we && addr == 2'd0 && unl_cnt == LAST) |=> rdata[7:4] == 4'h7);
  assert_idx_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && we && addr == 2'd2) |=> (wr_idx == $past(wdata) && wr_comp == 2'd0));
  assert_fixed_clk_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && !we && addr == 2'd3 && clk_sel && rd_idx == 8'd0 && rd_comp == 2'd0) |=> rdata == 8'h28);
  assert_single_byte_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cs && we && addr == 2'd3 && clk_sel && wr_idx == PLL_CTRL_IDX) |=> (wr_idx == PLL_CTRL_IDX + 8'd1 && wr_comp == 2'd0));
endmodule

bind dac_port_regs dac_port_regs_chk #(
  .UNLOCK_READS(UNLOCK_READS), .HAS_CHIP_ID(HAS_CHIP_ID), .PLL_CTRL_IDX(PLL_CTRL_IDX)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cs(cs), .we(we), .addr(addr), .wdata(wdata),
  .clk_sel(clk_sel), .rdata(rdata), .rd_valid(rd_valid), .pix_mask(pix_mask),
  .unl_cnt(unl_cnt), .cmd_q(cmd_q), .rd_idx(rd_idx), .rd_comp(rd_comp),
  .wr_idx(wr_idx), .wr_comp(wr_comp)
);

// File: tb/dac_port_regs_test.sv
`timescale 1ns/1ps
module dac_port_regs_test;
  localparam logic [1:0] A_MASK = 2'd0, A_RIDX = 2'd1, A_WIDX = 2'd2, A_DATA = 2'd3;
  localparam logic [7:0] ID_BYTE = 8'h73;

  logic clk = 1'b0, rst_n = 1'b0, cs = 1'b0, we = 1'b0, clk_sel = 1'b0;
  logic [1:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata, pix_mask, pclk_m, pclk_n;
  logic [1:0] pix_fmt;
  logic rd_valid;

  int checks = 0, errors = 0;
  bit finished = 1'b0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] exp_mask = 8'hFF;
  logic [7:0] exp_widx = 8'h00;

  always #5 clk = ~clk;

  dac_port_regs uut (
    .clk, .rst_n, .cs, .we, .addr, .wdata, .clk_sel,
    .rdata, .rd_valid, .pix_mask, .pix_fmt, .pclk_m, .pclk_n
  );

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", tag, act, exp);
    end
  endtask

  // Monitor: pops one expected byte per completed read
  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL R2: unexpected read result 0x%02h expected none", rdata);
      end else begin
        chk(rdata, exp_q.pop_front(), tag_q.pop_front());
      end
    end
  end

  task automatic op(input logic w, input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    cs = 1'b1; we = w; addr = a; wdata = d;
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string tag);
    op(1'b0, a, 8'h00);
    exp_q.push_back(exp);
    tag_q.push_back(tag);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    op(1'b1, a, d);
  endtask

  task automatic idle();
    @(negedge clk);
    cs = 1'b0; we = 1'b0;
  endtask

  task automatic set_mode(input logic m);
    @(negedge clk);
    cs = 1'b0; clk_sel = m;
  endtask

  // Clear count, then arm through four mask reads
  task automatic unlock();
    rd(A_WIDX, exp_widx, "R4 widx readback");
    for (int i = 0; i < 3; i++) rd(A_MASK, exp_mask, "R3 counted mask read");
    rd(A_MASK, ID_BYTE, "R5 chip id on fourth read");
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R1 reset state
    chk(pix_mask, 8'hFF, "R1 mask reset");
    chk({6'd0, pix_fmt}, 8'd0, "R1 format reset");
    chk({7'd0, rd_valid}, 8'd0, "R1 rd_valid reset");
    chk(pclk_m, 8'h00, "R1 pclk_m reset");
    rd(A_RIDX, 8'h00, "R1 read index reset");
    rd(A_DATA, 8'h00, "R1 palette zero");
    unlock();
    rd(A_MASK, 8'h00, "R1 command reset via hidden read");

    // R3/R12 hidden write and decode
    unlock();
    wr(A_MASK, 8'h60);
    idle();
    chk({6'd0, pix_fmt}, 8'd2, "R12 0x60 -> 565");
    chk(pix_mask, 8'hFF, "R3 mask untouched by hidden write");
    rd(A_MASK, 8'hFF, "R3 count restarted after hidden write");
    unlock();
    rd(A_MASK, 8'h60, "R3 hidden read returns command");
    rd(A_MASK, 8'hFF, "R3 count restarted after hidden read");
    unlock(); wr(A_MASK, 8'h20); idle();
    chk({6'd0, pix_fmt}, 8'd1, "R12 0x20 -> 555");
    unlock(); wr(A_MASK, 8'h40); idle();
    chk({6'd0, pix_fmt}, 8'd3, "R12 0x40 -> 32-bit");
    unlock(); wr(A_MASK, 8'h80); idle();
    chk({6'd0, pix_fmt}, 8'd0, "R12 0x80 -> palette on id variant");

    // R4 clearing rules
    rd(A_WIDX, 8'h00, "R4 clear");
    rd(A_MASK, 8'hFF, "R4 read 1");
    rd(A_MASK, 8'hFF, "R4 read 2");
    wr(A_MASK, 8'h0F);
    idle();
    chk(pix_mask, 8'h0F, "R4 early mask write reaches mask");
    exp_mask = 8'h0F;
    rd(A_MASK, 8'h0F, "R4 restart 1");
    rd(A_MASK, 8'h0F, "R4 restart 2");
    rd(A_MASK, 8'h0F, "R4 restart 3");
    rd(A_MASK, ID_BYTE, "R5 fourth after restart");
    rd(A_RIDX, 8'h00, "R4 index read clears armed count");
    rd(A_MASK, 8'h0F, "R4 not hidden after clear");
    rd(A_MASK, 8'h0F, "R4 second");
    rd(A_MASK, 8'h0F, "R4 third");
    rd(A_WIDX, 8'h00, "R4 widx read clears");
    rd(A_MASK, 8'h0F, "R4 no id after clear");
    rd(A_RIDX, 8'h00, "R4 clear again");
    wr(A_MASK, 8'hFF);
    idle();
    chk(pix_mask, 8'hFF, "R4 mask restored");
    exp_mask = 8'hFF;

    // R6/R7 palette triplets
    wr(A_WIDX, 8'h02);
    wr(A_DATA, 8'h11); wr(A_DATA, 8'h22); wr(A_DATA, 8'h33);
    wr(A_DATA, 8'h44); wr(A_DATA, 8'h55); wr(A_DATA, 8'h66);
    rd(A_WIDX, 8'h04, "R6 write index advanced two entries");
    wr(A_RIDX, 8'h02);
    rd(A_DATA, 8'h11, "R7 entry2 red");
    rd(A_DATA, 8'h22, "R7 entry2 green");
    rd(A_DATA, 8'h33, "R7 entry2 blue");
    rd(A_DATA, 8'h44, "R7 entry3 red");
    rd(A_RIDX, 8'h03, "R7 read index independent");
    rd(A_WIDX, 8'h04, "R7 write index unchanged by reads");
    wr(A_WIDX, 8'hFF);
    wr(A_DATA, 8'hA1); wr(A_DATA, 8'hA2); wr(A_DATA, 8'hA3); wr(A_DATA, 8'hB1);
    wr(A_RIDX, 8'hFF);
    rd(A_DATA, 8'hA1, "R6 entry255 red");
    rd(A_DATA, 8'hA2, "R6 entry255 green");
    rd(A_DATA, 8'hA3, "R6 entry255 blue");
    rd(A_DATA, 8'hB1, "R6 wrap to entry0 red");
    // R8 index reload restarts component pointer
    wr(A_WIDX, 8'h05); wr(A_DATA, 8'h77);
    wr(A_WIDX, 8'h05); wr(A_DATA, 8'h88);
    wr(A_RIDX, 8'h05);
    rd(A_DATA, 8'h88, "R8 reload restarts at red");
    rd(A_DATA, 8'h00, "R8 green untouched");
    rd(A_DATA, 8'h00, "R8 blue untouched");

    // R9/R10 clock bank
    set_mode(1'b1);
    wr(A_RIDX, 8'h00);
    rd(A_DATA, 8'h28, "R10 f0 M");
    rd(A_DATA, 8'h61, "R10 f0 N");
    rd(A_DATA, 8'h3D, "R10 f1 M");
    rd(A_DATA, 8'h62, "R10 f1 N");
    wr(A_WIDX, 8'h00);
    wr(A_DATA, 8'h01); wr(A_DATA, 8'h02); wr(A_DATA, 8'h03);
    wr(A_DATA, 8'h04); wr(A_DATA, 8'h05); wr(A_DATA, 8'h06);
    idle();
    chk(pclk_m, 8'h05, "R9 programmable M");
    chk(pclk_n, 8'h06, "R9 programmable N");
    wr(A_RIDX, 8'h00);
    rd(A_DATA, 8'h28, "R10 f0 M after write");
    rd(A_DATA, 8'h61, "R10 f0 N after write");
    rd(A_DATA, 8'h3D, "R10 f1 M after write");
    rd(A_DATA, 8'h62, "R10 f1 N after write");
    rd(A_DATA, 8'h05, "R9 entry2 M readback");
    rd(A_DATA, 8'h06, "R9 entry2 N readback");
    rd(A_RIDX, 8'h03, "R9 pair stepping");
    // R11 single-byte control index
    wr(A_WIDX, 8'h0E);
    wr(A_DATA, 8'h5A); wr(A_DATA, 8'h11); wr(A_DATA, 8'h22);
    wr(A_RIDX, 8'h0E);
    rd(A_DATA, 8'h5A, "R11 control byte");
    rd(A_DATA, 8'h11, "R11 next entry M");
    rd(A_DATA, 8'h22, "R11 next entry N");
    rd(A_RIDX, 8'h10, "R11 index after single byte");
    // R13 clock writes leave palette alone
    wr(A_WIDX, 8'h02);
    wr(A_DATA, 8'hEE); wr(A_DATA, 8'hEF);
    idle();
    chk(pclk_m, 8'hEE, "R9 entry2 M rewrite");
    set_mode(1'b0);
    wr(A_RIDX, 8'h02);
    rd(A_DATA, 8'h11, "R13 palette red kept");
    rd(A_DATA, 8'h22, "R13 palette green kept");
    rd(A_DATA, 8'h33, "R13 palette blue kept");

    idle();
    repeat (4) @(negedge clk);
    if (exp_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL R2: got %0d pending reads expected 0", exp_q.size());
    end
    finish_run();
  end
endmodule